// File: doc/BRIEF.md
# Two-Level Hot Path Predictor

This block forecasts which of the two most frequent paths through a loop body the next iteration will follow. It borrows the structure of two-level branch prediction: a shift register holds the outcome pattern of the last few iterations, and that pattern selects one small saturating counter from a table. Each time a loop iteration resolves, the outcome is presented on a valid/ready stream. The histories and tables update from that outcome, and a registered one-bit prediction is produced: path 1 or path 2.

Two comparison modes are selectable at run time. In threshold mode, the counter selected by the path-1 history is compared against a programmable threshold. In paired mode, a second history and a second table track path-2 occurrences. The counter selected by the path-1 history is then compared against the counter selected by the path-2 history.

The outcome stream never applies back-pressure: `oc_ready` is held high, and every cycle with `oc_valid` high is one accepted outcome. The mode and the threshold are plain control pins, sampled every cycle.

Top module: `hot_path_predictor`

## Requirements
- R1: A synchronous active-high reset clears both histories and all counters and drives the prediction to path 2 (`pred_p1` = 0) on the cycle after reset.
- R2: The outcome code on `oc_path` is 2'b01 for path 1 and 2'b10 for path 2; 2'b00 and 2'b11 mean some other path. `oc_ready` is always 1, and only cycles with `oc_valid` high change any state.
- R3: On each accepted outcome, the path-1 history shifts left and takes 1 in bit 0 when the outcome was path 1, and 0 otherwise.
- R4: On each accepted outcome, the path-1 counter indexed by the history value before the shift increments when the outcome was path 1 and decrements otherwise. No other counter changes.
- R5: Counters are unsigned and saturate: they never wrap above 2^CNT_W-1 and never go below 0.
- R6: When `mode_pair` is 0, the prediction is path 1 exactly when the selected path-1 counter is strictly greater than `thresh`.
- R7: The path-2 history and the path-2 table follow the rules of R3 and R4 with path 2 as the counted outcome.
- R8: When `mode_pair` is 1, the prediction is path 1 exactly when the selected path-1 counter is strictly greater than the selected path-2 counter. A tie predicts path 2.
- R9: `pred_p1` is registered. It reflects the table state, `mode_pair` and `thresh` as they stood at the previous clock edge.
- R10: Both histories and both tables update on every accepted outcome whatever the mode, so switching modes changes only the comparison used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_valid | input | 1 | Resolved outcome present |
| oc_ready | output | 1 | Outcome accepted (always 1) |
| oc_path | input | 2 | Outcome code: 01 path 1, 10 path 2, else other |
| mode_pair | input | 1 | 0 threshold mode, 1 paired-table mode |
| thresh | input | CNT_W | Threshold for threshold mode |
| pred_p1 | output | 1 | 1 predicts path 1, 0 predicts path 2 |

## Verification
The bench builds the block with a 4-bit history and 3-bit counters. The narrow counters reach both saturation limits within a handful of outcomes. The 16-entry tables let randomly mixed outcome streams revisit every history pattern many times. Directed runs of repeated path 1, repeated path 2 and other-only outcomes drive the counters to their limits and create counter ties in paired mode. Mode switches and mid-run resets check that the comparison changes while the stored state does not.

// File: rtl/hpp_pkg.sv
package hpp_pkg;
  typedef enum logic [1:0] {
    OC_OTHER_A = 2'b00,
    OC_FIRST   = 2'b01,
    OC_SECOND  = 2'b10,
    OC_OTHER_B = 2'b11
  } oc_code_e;

  function automatic logic is_first(input logic [1:0] code);
    return code == OC_FIRST;
  endfunction

  function automatic logic is_second(input logic [1:0] code);
    return code == OC_SECOND;
  endfunction
endpackage

// File: rtl/hpp_history.sv
module hpp_history #(
  parameter int HIST_LEN = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [HIST_LEN-1:0] hist
);
  generate
    if (HIST_LEN == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[HIST_LEN-2:0], bit_in};
      end
    end
  endgenerate

  AST_HIST_NEWBIT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[0] == $past(bit_in)); // R3
  AST_HIST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist)); // R2
endmodule

// File: rtl/hpp_counter_table.sv
module hpp_counter_table #(
  parameter int HIST_LEN = 4,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic [HIST_LEN-1:0] idx,
  input  logic                inc,
  output logic [CNT_W-1:0]    rd_cnt
);
  localparam int DEPTH = 1 << HIST_LEN;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) begin
        cnt_q[i] <= '0;
      end else if (upd && idx == HIST_LEN'(i)) begin
        if (inc) cnt_q[i] <= (cnt_q[i] == CMAX) ? CMAX : cnt_q[i] + 1'b1;
        else     cnt_q[i] <= (cnt_q[i] == '0)   ? '0   : cnt_q[i] - 1'b1;
      end
    end
  end

  always_comb rd_cnt = cnt_q[idx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
      AST_CNT_TOP: assert property (@(posedge clk) disable iff (rst)
        (upd && idx == HIST_LEN'(g) && inc && cnt_q[g] == CMAX) |=> cnt_q[g] == CMAX); // R5
      AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (upd && idx == HIST_LEN'(g) && !inc && cnt_q[g] == '0) |=> cnt_q[g] == '0); // R5
      AST_CNT_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        !(upd && idx == HIST_LEN'(g)) |=> $stable(cnt_q[g])); // R4
    end
  endgenerate
endmodule

// File: rtl/hpp_select.sv
module hpp_select #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_pair,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             pred_p1
);
  logic [CNT_W-1:0] rhs;
  always_comb rhs = mode_pair ? cnt_b : thresh;

  always_ff @(posedge clk) begin
    if (rst) pred_p1 <= 1'b0;
    else     pred_p1 <= cnt_a > rhs;
  end

  AST_PRED_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pred_p1); // R1
  AST_PAIR_TIE: assert property (@(posedge clk) disable iff (rst)
    (mode_pair && cnt_a == cnt_b) |=> !pred_p1); // R8
  AST_THR_BELOW: assert property (@(posedge clk) disable iff (rst)
    (!mode_pair && cnt_a <= thresh) |=> !pred_p1); // R6
endmodule

// File: rtl/hot_path_predictor.sv
module hot_path_predictor #(
  parameter int HIST_LEN = 4,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oc_valid,
  output logic             oc_ready,
  input  logic [1:0]       oc_path,
  input  logic             mode_pair,
  input  logic [CNT_W-1:0] thresh,
  output logic             pred_p1
);
  import hpp_pkg::*;

  logic                accept;
  logic                hit_a, hit_b;
  logic [HIST_LEN-1:0] hist_a, hist_b;
  logic [CNT_W-1:0]    cnt_a, cnt_b;

  assign oc_ready = 1'b1;
  assign accept   = oc_valid && oc_ready;
  assign hit_a    = is_first(oc_path);
  assign hit_b    = is_second(oc_path);

  hpp_history #(.HIST_LEN(HIST_LEN)) u_hist_a (
    .clk(clk), .rst(rst), .shift_en(accept), .bit_in(hit_a), .hist(hist_a));
  hpp_history #(.HIST_LEN(HIST_LEN)) u_hist_b (
    .clk(clk), .rst(rst), .shift_en(accept), .bit_in(hit_b), .hist(hist_b));

  hpp_counter_table #(.HIST_LEN(HIST_LEN), .CNT_W(CNT_W)) u_tab_a (
    .clk(clk), .rst(rst), .upd(accept), .idx(hist_a), .inc(hit_a), .rd_cnt(cnt_a));
  hpp_counter_table #(.HIST_LEN(HIST_LEN), .CNT_W(CNT_W)) u_tab_b (
    .clk(clk), .rst(rst), .upd(accept), .idx(hist_b), .inc(hit_b), .rd_cnt(cnt_b));

  hpp_select #(.CNT_W(CNT_W)) u_sel (
    .clk(clk), .rst(rst), .mode_pair(mode_pair), .thresh(thresh),
    .cnt_a(cnt_a), .cnt_b(cnt_b), .pred_p1(pred_p1));

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    oc_ready); // R2
  AST_B_TRACKS_SECOND: assert property (@(posedge clk) disable iff (rst)
    (oc_valid && oc_path == OC_SECOND) |=> hist_b[0] && !hist_a[0]); // R7
  AST_MODE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (!oc_valid && mode_pair != $past(mode_pair)) |=> $stable(hist_a) && $stable(hist_b)); // R10
endmodule

// File: tb/hot_path_predictor_tb.sv
module hot_path_predictor_tb;
  localparam int HL    = 4;
  localparam int CW    = 3;
  localparam int DEPTH = 1 << HL;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          oc_valid = 1'b0;
  logic          oc_ready;
  logic [1:0]    oc_path = 2'b00;
  logic          mode_pair = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          pred_p1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int  m_ha, m_hb;
  int  m_ca [DEPTH];
  int  m_cb [DEPTH];
  bit  exp_pred;

  always #2 clk = ~clk;

  hot_path_predictor #(.HIST_LEN(HL), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .oc_valid(oc_valid), .oc_ready(oc_ready),
    .oc_path(oc_path), .mode_pair(mode_pair), .thresh(thresh), .pred_p1(pred_p1));

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > CMAX) return CMAX;
    return v;
  endfunction

  function automatic bit predict(input bit pm, input int t, input int a, input int b);
    return pm ? (a > b) : (a > t);
  endfunction

  task automatic model_edge();
    bit pa, pb;
    if (rst) begin
      exp_pred = 1'b0;
      m_ha = 0; m_hb = 0;
      for (int i = 0; i < DEPTH; i++) begin m_ca[i] = 0; m_cb[i] = 0; end
    end else begin
      exp_pred = predict(mode_pair, int'(thresh), m_ca[m_ha], m_cb[m_hb]);
      if (oc_valid) begin
        pa = (oc_path == 2'b01);
        pb = (oc_path == 2'b10);
        m_ca[m_ha] = sat(m_ca[m_ha] + (pa ? 1 : -1));
        m_cb[m_hb] = sat(m_cb[m_hb] + (pb ? 1 : -1));
        m_ha = ((m_ha << 1) | int'(pa)) & (DEPTH - 1);
        m_hb = ((m_hb << 1) | int'(pb)) & (DEPTH - 1);
      end
    end
  endtask

  task automatic check(input string req, input logic act, input logic expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] p, input bit pm,
                      input logic [CW-1:0] t, input string req);
    oc_valid = v; oc_path = p; mode_pair = pm; thresh = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, pred_p1, exp_pred);
    check("R2 ready", oc_ready, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(posedge clk); model_edge();
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); model_edge();
    @(negedge clk);
    check("R1 reset pred", pred_p1, 1'b0);
    // R1: first prediction in paired mode with equal counters is path 2
    step(0, 2'b00, 1, 3'd0, "R1 R8 tie after reset");
    // R3 R4 R5: repeated path 1 saturates counter at all-ones history
    for (int i = 0; i < 14; i++) step(1, 2'b01, 0, 3'd6, "R3 R4 R5 R6 path1 run");
    step(0, 2'b00, 0, 3'd6, "R6 above thresh");
    step(0, 2'b00, 0, 3'd7, "R6 equal not greater");
    step(0, 2'b00, 1, 3'd7, "R10 mode switch pair");
    // R7: path 2 run, then paired compare
    for (int i = 0; i < 14; i++) step(1, 2'b10, 1, 3'd0, "R7 R8 path2 run");
    // R5: other-only floors both tables
    for (int i = 0; i < 12; i++) step(1, ($urandom_range(1) != 0) ? 2'b11 : 2'b00,
                                       i[0], 3'd0, "R5 other floor");
    // R2: invalid cycles change nothing
    for (int i = 0; i < 6; i++) step(0, 2'b01, i[1], 3'd1, "R2 idle");
    // R9 R10: random mix
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(3) != 0, 2'($urandom_range(3)), $urandom_range(7) < 3,
           CW'($urandom_range(CMAX)), "R9 R4 R6 R8 random");
      if (i == 1500) begin
        rst = 1'b1;
        step(0, 2'b00, 0, 3'd0, "R1 mid reset");
        rst = 1'b0;
        step(0, 2'b00, 1, 3'd0, "R1 post reset");
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule